// File: doc/BRIEF.md
# Programmable Clock Source Divider

This block derives a processor-domain clock from one of three reference inputs: a slow internal RC oscillator, a 24 MHz crystal and a PLL output. It then divides that clock by a linear factor M (1 to 32), followed by a power-of-two factor N (1, 2, 4 or 8). From the processor clock it also derives a bus clock through a power-of-two ratio stage. All clocks are modelled as single-cycle enable pulses in one simulation clock domain. Each reference input is a tick that marks one of its cycles. The outputs `proc_en` and `bus_en` mark the divided clock periods.

Software programs the block through a small register interface. Address 0 holds the source, M and N fields. Address 1 holds the bus ratio field. A write that changes the source starts a settling window of at least eight cycles. During that window the outputs stay quiet, and `switch_busy` reports that a switch is pending. A change of M or N waits for the end of the current output period, so no period is cut short.

Top module: `proc_clk_divider`

## Requirements
- R1: After reset, the address-0 word reads 0x0001_0010 (source 1 = crystal, M field 0 = divide by 1, N field 1 = divide by 2). The address-1 word reads 0, and `switch_busy` is 0.
- R2: At address 0 the source field reads in bits 17:16, M in bits 12:8 and N in bits 5:4. At address 1 the bus ratio reads in bits 1:0. Every other bit reads 0, whatever was written.
- R3: Source code 0 selects `ref_rc_tick`, code 1 selects `ref_xtal_tick` and code 2 selects `ref_pll_tick`. In steady state, consecutive `proc_en` pulses are (M+1)·2^N ticks of the selected input apart.
- R4: A write of source code 3 (reserved) leaves the source field and the active source unchanged and does not raise `switch_busy`. The M and N fields in the same write are still accepted.
- R5: A write with a source code other than 3 and other than the current one raises `switch_busy` for exactly SETTLE_CYCLES cycles (default 8). The new source takes over after that window.
- R6: No `proc_en` or `bus_en` pulse occurs while `switch_busy` is 1.
- R7: A new M or N value applies from the next output period boundary. The period in progress completes with the old ratio.
- R8: `bus_en` pulses once every B `proc_en` pulses, always in the same cycle as a `proc_en` pulse. Bus codes 1, 2 and 3 give B = 2, 4 and 8. Code 0 gives B = 1, or B = 2 when BUS_CODE0_DIV2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation/system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_rc_tick | input | 1 | One pulse per cycle of the internal RC reference |
| ref_xtal_tick | input | 1 | One pulse per cycle of the crystal reference |
| ref_pll_tick | input | 1 | One pulse per cycle of the PLL reference |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 = divider config, 1 = bus ratio |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 32 | Combinational readback of the addressed word |
| switch_busy | output | 1 | 1 while a source switch is settling |
| proc_en | output | 1 | Processor clock enable pulse |
| bus_en | output | 1 | Bus clock enable pulse |

## Verification
The bench attacks the reserved source code. A design that took code 3 as a real source would go silent or read back 3. It times the settling window to the cycle, which catches a counter that is one short or that lets a stray pulse through while busy. It writes new M and N values in the middle of a period: a design that reloads at once would shorten that period, and the bench would see a wrong interval. It sweeps every bus ratio code, including code 0, and checks that bus pulses never appear without a processor pulse.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam logic [1:0] SRC_RC   = 2'd0;
   localparam logic [1:0] SRC_XTAL = 2'd1;
   localparam logic [1:0] SRC_PLL  = 2'd2;
   localparam logic [1:0] SRC_RSVD = 2'd3;

   // field positions inside the address-0 word
   localparam int SRC_LO = 16;
   localparam int M_LO   = 8;
   localparam int N_LO   = 4;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
   import clkdiv_pkg::*;
#(
   parameter int M_W   = 5,
   parameter int N_W   = 2,
   parameter int BUS_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [31:0]      wr_data,
   input  logic             rd_addr,
   output logic [31:0]      rd_data,
   output logic [1:0]       src_q,
   output logic [M_W-1:0]   m_q,
   output logic [N_W-1:0]   n_q,
   output logic [BUS_W-1:0] bus_q,
   output logic             src_start
);
   logic [1:0] code;
   logic       unused_wr;

   assign code      = wr_data[SRC_LO +: 2];
   assign unused_wr = ^wr_data;
   assign src_start = wr_en && !wr_addr && (code != SRC_RSVD) && (code != src_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= SRC_XTAL;
         m_q   <= '0;
         n_q   <= N_W'(1);
         bus_q <= '0;
      end else if (wr_en) begin
         if (!wr_addr) begin
            m_q <= wr_data[M_LO +: M_W];
            n_q <= wr_data[N_LO +: N_W];
            if (code != SRC_RSVD) src_q <= code;
         end else begin
            bus_q <= wr_data[BUS_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (!rd_addr) begin
         rd_data[SRC_LO +: 2] = src_q;
         rd_data[M_LO +: M_W] = m_q;
         rd_data[N_LO +: N_W] = n_q;
      end else begin
         rd_data[BUS_W-1:0] = bus_q;
      end
   end
endmodule

// File: rtl/clkdiv_src_switch.sv
module clkdiv_src_switch
   import clkdiv_pkg::*;
#(
   parameter int SETTLE = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] req,
   output logic [1:0] active,
   output logic       busy
);
   localparam int CW = $clog2(SETTLE + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         active <= SRC_XTAL;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == CW'(SETTLE - 1)) begin
            busy   <= 1'b0;
            active <= req;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/clkdiv_ratio_div.sv
module clkdiv_ratio_div #(
   parameter int M_W = 5,
   parameter int N_W = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold,
   input  logic           tick,
   input  logic [M_W-1:0] m,
   input  logic [N_W-1:0] n,
   output logic           wrap,
   output logic           proc_en
);
   localparam int MAX_SHIFT = (1 << N_W) - 1;
   localparam int MAX_RATIO = (1 << M_W) << MAX_SHIFT;
   localparam int CNT_W     = $clog2(MAX_RATIO + 1);

   logic [CNT_W-1:0] ratio, eff, cnt;

   assign ratio = (CNT_W'(m) + CNT_W'(1)) << n;
   assign wrap  = !hold && tick && (cnt == eff - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         eff     <= CNT_W'(2);
         proc_en <= 1'b0;
      end else begin
         proc_en <= wrap;
         if (hold) begin
            cnt <= '0;
            eff <= ratio;
         end else if (tick) begin
            if (wrap) begin
               cnt <= '0;
               eff <= ratio;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/clkdiv_bus_div.sv
module clkdiv_bus_div #(
   parameter int BUS_W          = 2,
   parameter bit BUS_CODE0_DIV2 = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             wrap,
   input  logic [BUS_W-1:0] code,
   output logic             bus_en
);
   localparam int MAX_DIV = 1 << ((1 << BUS_W) - 1);
   localparam int DW      = $clog2(MAX_DIV + 1);

   logic [DW-1:0] bdiv, bcnt;

   generate
      if (BUS_CODE0_DIV2) begin : g_code0_half
         assign bdiv = (code == '0) ? DW'(2) : (DW'(1) << code);
      end else begin : g_code0_pass
         assign bdiv = DW'(1) << code;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt   <= '0;
         bus_en <= 1'b0;
      end else if (hold) begin
         bcnt   <= '0;
         bus_en <= 1'b0;
      end else if (wrap) begin
         if (bcnt >= bdiv - 1'b1) begin
            bcnt   <= '0;
            bus_en <= 1'b1;
         end else begin
            bcnt   <= bcnt + 1'b1;
            bus_en <= 1'b0;
         end
      end else begin
         bus_en <= 1'b0;
      end
   end
endmodule

// File: rtl/proc_clk_divider.sv
module proc_clk_divider
   import clkdiv_pkg::*;
#(
   parameter int M_W            = 5,
   parameter int N_W            = 2,
   parameter int BUS_W          = 2,
   parameter int SETTLE_CYCLES  = 8,
   parameter bit BUS_CODE0_DIV2 = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ref_rc_tick,
   input  logic        ref_xtal_tick,
   input  logic        ref_pll_tick,
   input  logic        wr_en,
   input  logic        wr_addr,
   input  logic [31:0] wr_data,
   input  logic        rd_addr,
   output logic [31:0] rd_data,
   output logic        switch_busy,
   output logic        proc_en,
   output logic        bus_en
);
   generate
      if (SETTLE_CYCLES < 8) begin : g_bad_settle
         $error("SETTLE_CYCLES must be at least 8");
      end
      if (M_W < 1 || M_W > 5) begin : g_bad_m
         $error("M_W must fit bits 12:8");
      end
      if (N_W < 1 || N_W > 2) begin : g_bad_n
         $error("N_W must fit bits 5:4");
      end
      if (BUS_W < 1 || BUS_W > 2) begin : g_bad_bus
         $error("BUS_W must be 1 or 2");
      end
   endgenerate

   logic [1:0]       src_req, src_act;
   logic [M_W-1:0]   m_q;
   logic [N_W-1:0]   n_q;
   logic [BUS_W-1:0] bus_q;
   logic             src_start, hold, sel_tick, wrap;

   clkdiv_regs #(.M_W(M_W), .N_W(N_W), .BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .src_q(src_req), .m_q(m_q), .n_q(n_q), .bus_q(bus_q),
      .src_start(src_start)
   );

   clkdiv_src_switch #(.SETTLE(SETTLE_CYCLES)) u_switch (
      .clk(clk), .rst_n(rst_n), .start(src_start), .req(src_req),
      .active(src_act), .busy(switch_busy)
   );

   always_comb begin
      case (src_act)
         SRC_RC:  sel_tick = ref_rc_tick;
         SRC_PLL: sel_tick = ref_pll_tick;
         default: sel_tick = ref_xtal_tick;
      endcase
   end

   assign hold = switch_busy | src_start;

   clkdiv_ratio_div #(.M_W(M_W), .N_W(N_W)) u_div (
      .clk(clk), .rst_n(rst_n), .hold(hold), .tick(sel_tick),
      .m(m_q), .n(n_q), .wrap(wrap), .proc_en(proc_en)
   );

   clkdiv_bus_div #(.BUS_W(BUS_W), .BUS_CODE0_DIV2(BUS_CODE0_DIV2)) u_bus (
      .clk(clk), .rst_n(rst_n), .hold(hold), .wrap(wrap),
      .code(bus_q), .bus_en(bus_en)
   );
endmodule

// File: rtl/proc_clk_divider_chk.sv
module proc_clk_divider_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_addr,
   input logic [31:0] wr_data,
   input logic        rd_addr,
   input logic [31:0] rd_data,
   input logic [1:0]  src_req,
   input logic        switch_busy,
   input logic        proc_en,
   input logic        bus_en
);
   p_rsvd_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_addr |-> ((rd_data & ~32'h0003_1F30) == 32'h0))
      else $error("reserved bits of config word not zero");

   p_bus_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr |-> (rd_data[31:2] == 30'h0))
      else $error("reserved bits of bus word not zero");

   p_rsvd_code_keeps_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && wr_data[17:16] == 2'd3) |=> $stable(src_req))
      else $error("reserved source code changed source");

   p_new_src_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && wr_data[17:16] != 2'd3 && wr_data[17:16] != src_req)
      |=> switch_busy)
      else $error("source change did not start settling");

   p_quiet_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      switch_busy |-> (!proc_en && !bus_en))
      else $error("pulse during settling window");

   p_bus_with_proc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_en |-> proc_en)
      else $error("bus pulse without processor pulse");
endmodule

bind proc_clk_divider proc_clk_divider_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
   .src_req(src_req), .switch_busy(switch_busy),
   .proc_en(proc_en), .bus_en(bus_en)
);

// File: tb/proc_clk_divider_tb.sv
`timescale 1ns/1ps
module proc_clk_divider_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rc_t = 1'b0, xt_t = 1'b0, pl_t = 1'b0;
   logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        busy, proc_en, bus_en;

   int checks = 0, fails = 0;
   int cyc = 0;
   int proc_cnt = 0, proc_t = 0, proc_iv = 0;
   int bus_cnt = 0, bus_t = 0, bus_iv = 0;
   int busy_cyc = 0, busy_pulse = 0, lone_bus = 0;

   proc_clk_divider u_dut (
      .clk(clk), .rst_n(rst_n), .ref_rc_tick(rc_t), .ref_xtal_tick(xt_t),
      .ref_pll_tick(pl_t), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .switch_busy(busy),
      .proc_en(proc_en), .bus_en(bus_en)
   );

   initial forever #10 clk = ~clk;

   // reference periods in system cycles: rc 3, xtal 2, pll 1
   function automatic int src_period(int s);
      return (s == 0) ? 3 : (s == 1) ? 2 : 1;
   endfunction
   function automatic int ratio(int m, int n);
      return (m + 1) << n;
   endfunction
   function automatic int bus_div(int code);
      return 1 << code;
   endfunction
   function automatic logic [31:0] cfg(int s, int m, int n);
      logic [31:0] w = '0;
      w[17:16] = 2'(s);
      w[12:8]  = 5'(m);
      w[5:4]   = 2'(n);
      return w;
   endfunction

   // reference ticks and output monitor, all at the falling edge
   initial forever begin
      @(negedge clk);
      cyc++;
      if (proc_en) begin
         if (proc_cnt > 0) proc_iv = cyc - proc_t;
         proc_t = cyc;
         proc_cnt++;
      end
      if (bus_en) begin
         if (bus_cnt > 0) bus_iv = cyc - bus_t;
         bus_t = cyc;
         bus_cnt++;
         if (!proc_en) lone_bus++;
      end
      if (busy) begin
         busy_cyc++;
         if (proc_en || bus_en) busy_pulse++;
      end
      rc_t = (cyc % 3 == 0);
      xt_t = (cyc % 2 == 0);
      pl_t = 1'b1;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic a, output logic [31:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic wait_idle();
      @(posedge clk);
      while (busy) @(posedge clk);
   endtask

   task automatic wait_proc(int k);
      int target = proc_cnt + k;
      while (proc_cnt < target) @(posedge clk);
   endtask

   task automatic wait_bus(int k);
      int target = bus_cnt + k;
      while (bus_cnt < target) @(posedge clk);
   endtask

   // settle the new setting, skip two pulses, return the steady interval
   task automatic measure(output int iv);
      wait_idle();
      wait_proc(3);
      iv = proc_iv;
   endtask

   initial begin
      logic [31:0] d;
      int iv;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(1'b0, d); chk("R1 cfg word", d, 32'h0001_0010);
      rd(1'b1, d); chk("R1 bus word", d, 32'h0);
      chk("R1 busy", {31'b0, busy}, 32'h0);
      measure(iv); chk("R3 default xtal /2", iv, 32'(2 * 2));

      // R2 reserved bits read zero
      wr(1'b0, 32'hFFFE_FFFF);
      rd(1'b0, d); chk("R2 cfg readback", d, 32'h0002_1F30);
      wr(1'b1, 32'hFFFF_FFFD);
      rd(1'b1, d); chk("R2 bus readback", d, 32'h0000_0001);
      wr(1'b1, 32'h0);
      wait_idle();

      // R5 settling length, R6 quiet window
      busy_cyc = 0; busy_pulse = 0;
      wr(1'b0, cfg(0, 2, 1));
      wait_idle();
      chk("R5 settle cycles", busy_cyc, 32'd8);
      chk("R6 pulses while busy", busy_pulse, 32'd0);

      // R3 each source
      for (int s = 0; s < 3; s++) begin
         wr(1'b0, cfg(s, 2, 1));
         measure(iv);
         chk($sformatf("R3 source %0d interval", s), iv, 32'(ratio(2, 1) * src_period(s)));
      end

      // R4 reserved source code: pll stays, M/N taken
      busy_cyc = 0;
      wr(1'b0, cfg(3, 4, 0));
      rd(1'b0, d); chk("R4 readback keeps source", d, cfg(2, 4, 0));
      chk("R4 no busy", busy_cyc, 32'd0);
      measure(iv); chk("R4 interval on pll", iv, 32'(ratio(4, 0) * 1));

      // R7 mid-period change: xtal, ratio 4 -> 10
      wr(1'b0, cfg(1, 3, 0));
      measure(iv); chk("R7 old ratio", iv, 32'd8);
      wait_proc(1);
      wr(1'b0, cfg(1, 4, 1));
      wait_proc(1); chk("R7 period not truncated", proc_iv, 32'd8);
      wait_proc(1); chk("R7 new ratio next period", proc_iv, 32'd20);

      // R8 bus ratios on pll, proc ratio 2
      wr(1'b0, cfg(2, 1, 0));
      wait_idle();
      for (int c = 0; c < 4; c++) begin
         wr(1'b1, 32'(c));
         wait_bus(3);
         chk($sformatf("R8 bus code %0d interval", c), bus_iv, 32'(2 * bus_div(c)));
      end
      chk("R8 bus without proc", lone_bus, 32'd0);
      wr(1'b1, 32'h0);

      // random configurations (R3, R7)
      for (int i = 0; i < 12; i++) begin
         int s = int'($urandom % 3);
         int m = int'($urandom % 32);
         int n = int'($urandom % 4);
         wr(1'b0, cfg(s, m, n));
         rd(1'b0, d); chk("R2 random readback", d, cfg(s, m, n));
         measure(iv);
         chk($sformatf("R3 random s%0d m%0d n%0d", s, m, n), iv,
             32'(ratio(m, n) * src_period(s)));
      end
      chk("R6 random pulses while busy", busy_pulse, 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule